// File: doc/BRIEF.md
# Strided Address Stream Generator

This block produces the memory address streams for a processor whose arithmetic side is decoupled from its addressing side. It holds a read base and a write base, each with its own stride. Each address step adds the stride to its base, keeps the sum as the new base, and presents that sum as a push into a downstream read-address FIFO or write-address FIFO. A step whose target FIFO is full, or that arrives while the wait input is high, waits with all state intact. The block runs at most one step per clock.

The loop pattern is fixed and is selected by configuration. In the plain pattern, each iteration emits one read and then one write for the same element. In the lagged pattern, a leading read comes first, each iteration emits a read and then a write for the previous element, and a trailing write closes the run, so writes lag reads by one iteration. An optional constant-operand read can be issued once before the vector loop. An optional drain wait holds the run open until the write FIFO reports empty. A start pulse begins a run, a stop pulse aborts it, and the generator clears its own running flag when the pattern completes.

Top module: `strided_addr_gen`

## Requirements
- R1: A read step presents read base plus read stride on `rd_addr` with `rd_push` high and stores that sum as the new read base. A write step does the same with the write base and write stride on `wr_addr`/`wr_push`. The first read of a run is therefore the configured base plus one stride.
- R2: A step whose target FIFO is full, or any step while `hold` is high, issues no push and changes no base or count. The step issues its push in the first cycle in which the target is not full and `hold` is low. A push never occurs while its target full input is high.
- R3: In plain mode (mode bit0 = 0), with the loop count programmed as N-1, the run emits exactly N iterations in the order read, write, read, write. The count is tested after each write, and the loop repeats while the decremented count is still non-negative.
- R4: In lagged mode (mode bit0 = 1), the run emits one leading read, then N-1 iterations of read followed by write, then one trailing write. That gives N reads and N writes. For N = 1 the run is a read followed by a write.
- R5: With mode bit1 = 1, the constant-operand register is pushed once as a read address before any strided address. It leaves the read base unchanged.
- R6: `running` rises in the cycle after an accepted start. Without drain wait it falls in the cycle after the last push. While `running` is low, neither push is asserted.
- R7: With mode bit2 = 1, after the last push the run stays active with no pushes until `wr_empty` is sampled high. `running` falls in the cycle after that.
- R8: Base arithmetic wraps modulo 2^16.
- R9: A start pulse while running has no effect. Configuration writes while running are ignored.
- R10: A `stop` pulse while running suppresses any push in that cycle and clears `running` in the next cycle. No further pushes follow.
- R11: Synchronous active-low reset clears all bases, strides, count, constant and mode to zero and leaves `running` low. A start with that state therefore emits read 0 and then write 0.
- R12: Configuration writes (`cfg_we` high while halted) select by `cfg_sel`: 0 read base, 1 read stride, 2 write base, 3 write stride, 4 loop count N-1, 5 constant address, 6 mode (bit0 lagged writes, bit1 constant read, bit2 drain wait).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_data | input | 16 | Configuration write data |
| start | input | 1 | Start pulse, taken only while halted |
| stop | input | 1 | Abort pulse |
| hold | input | 1 | Wait control, pauses stepping |
| rd_full | input | 1 | Read-address FIFO full |
| wr_full | input | 1 | Write-address FIFO full |
| wr_empty | input | 1 | Write-address FIFO empty |
| rd_push | output | 1 | Push into read-address FIFO |
| rd_addr | output | 16 | Read address being pushed |
| wr_push | output | 1 | Push into write-address FIFO |
| wr_addr | output | 16 | Write address being pushed |
| running | output | 1 | Run flag |

## Verification
Runs with free FIFOs give the order and addresses of the plain, lagged and constant-read patterns with no stall in the way. Random full and hold patterns on both FIFOs then show whether a stalled step keeps its place and its base, since any lost or repeated step shifts every later address. Short counts (N = 1), wrapping bases and a drain run with a late empty probe the loop boundaries and the finish timing. Starts, configuration writes and stops injected mid-run show whether control inputs disturb a run in progress.

// File: rtl/asg_pkg.sv
// Shared types and configuration encodings for the strided address generator.
package asg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CONST, ST_LEAD, ST_RD, ST_WR, ST_TRAIL, ST_DRAIN
    } asg_state_e;

    localparam int SELW = 3;
    localparam logic [SELW-1:0] SEL_RBASE   = 3'd0;
    localparam logic [SELW-1:0] SEL_RSTRIDE = 3'd1;
    localparam logic [SELW-1:0] SEL_WBASE   = 3'd2;
    localparam logic [SELW-1:0] SEL_WSTRIDE = 3'd3;
    localparam logic [SELW-1:0] SEL_COUNT   = 3'd4;
    localparam logic [SELW-1:0] SEL_CONST   = 3'd5;
    localparam logic [SELW-1:0] SEL_MODE    = 3'd6;

    localparam int MODE_LAG   = 0;
    localparam int MODE_CONST = 1;
    localparam int MODE_DRAIN = 2;
    localparam int MODEW      = 3;
endpackage

// File: rtl/asg_lane.sv
// One address lane: a base register and a stride register.
// nxt is always base + stride (wrapping). A step commits nxt into base.
// Assumes the loads come only from halted configuration writes.
module asg_lane #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_ld,
    input  logic          stride_ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] base;
    logic [AW-1:0] stride;

    // next address: modulo 2^AW sum
    always_comb nxt = base + stride;

    // base and stride registers: load from config, advance on a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            stride <= '0;
        end else begin
            if (base_ld)      base <= ld_val;
            else if (step)    base <= nxt;
            if (stride_ld)    stride <= ld_val;
        end
    end

    // a stalled lane keeps its base
    p_base_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !base_ld) |=> base == $past(base));
endmodule

// File: rtl/asg_seq.sv
// Step sequencer: walks const / lead / read / write / trail / drain states.
// It issues at most one step per cycle and stalls on a full target or on hold.
// Assumes cnt_init and the mode bits stay stable while running.
module asg_seq #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          hold,
    input  logic          rd_full,
    input  logic          wr_full,
    input  logic          wr_empty,
    input  logic [CW-1:0] cnt_init,
    input  logic          lag,
    input  logic          cen,
    input  logic          drain,
    output logic          rd_step,
    output logic          wr_step,
    output logic          const_sel,
    output logic          running
);
    import asg_pkg::*;

    asg_state_e    state;
    logic [CW-1:0] cnt;
    logic          tgt_rd, tgt_wr, go, last;
    asg_state_e    fin_st, first_st, post_const_st;

    // step qualification and successor choices
    always_comb begin
        tgt_rd        = (state == ST_CONST) || (state == ST_LEAD) || (state == ST_RD);
        tgt_wr        = (state == ST_WR) || (state == ST_TRAIL);
        go            = !stop && !hold &&
                        ((tgt_rd && !rd_full) || (tgt_wr && !wr_full));
        rd_step       = go && tgt_rd;
        wr_step       = go && tgt_wr;
        const_sel     = (state == ST_CONST);
        running       = (state != ST_IDLE);
        last          = (cnt == '0);
        fin_st        = drain ? ST_DRAIN : ST_IDLE;
        post_const_st = lag ? ST_LEAD : ST_RD;
        first_st      = cen ? ST_CONST : post_const_st;
    end

    // state and loop counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (stop && state != ST_IDLE) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= first_st;
                    cnt   <= cnt_init;
                end
                ST_CONST: if (go) state <= post_const_st;
                ST_LEAD: if (go) begin
                    if (last) state <= ST_TRAIL;
                    else begin
                        cnt   <= cnt - 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_RD: if (go) state <= ST_WR;
                ST_WR: if (go) begin
                    if (last) state <= lag ? ST_TRAIL : fin_st;
                    else begin
                        cnt   <= cnt - 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_TRAIL: if (go) state <= fin_st;
                ST_DRAIN: if (wr_empty) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // drain holds until the write FIFO reports empty
    p_drain_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !wr_empty && !stop) |=> state == ST_DRAIN);

    // a stalled step leaves the loop count alone
    p_count_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !go) |=> $stable(cnt));
endmodule

// File: rtl/strided_addr_gen.sv
// Strided address stream generator top.
// Holds the configuration, two address lanes and the sequencer.
// Drives push strobes combinationally from registered state and the FIFO
// flags of the same cycle. Configuration is accepted only while halted.
module strided_addr_gen #(
    parameter int AW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [asg_pkg::SELW-1:0] cfg_sel,
    input  logic [AW-1:0]           cfg_data,
    input  logic                    start,
    input  logic                    stop,
    input  logic                    hold,
    input  logic                    rd_full,
    input  logic                    wr_full,
    input  logic                    wr_empty,
    output logic                    rd_push,
    output logic [AW-1:0]           rd_addr,
    output logic                    wr_push,
    output logic [AW-1:0]           wr_addr,
    output logic                    running
);
    import asg_pkg::*;

    logic                cfg_ok;
    logic [AW-1:0]       cnt_cfg;
    logic [AW-1:0]       const_addr;
    logic [MODEW-1:0]    mode;
    logic                rd_step, wr_step, const_sel;
    logic [AW-1:0]       rd_nxt;

    // configuration is blocked during a run
    always_comb cfg_ok = cfg_we && !running;

    // count, constant and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_cfg    <= '0;
            const_addr <= '0;
            mode       <= '0;
        end else if (cfg_ok) begin
            if (cfg_sel == SEL_COUNT) cnt_cfg    <= cfg_data;
            if (cfg_sel == SEL_CONST) const_addr <= cfg_data;
            if (cfg_sel == SEL_MODE)  mode       <= cfg_data[MODEW-1:0];
        end
    end

    asg_lane #(.AW(AW)) u_rd_lane (
        .clk(clk), .rst_n(rst_n),
        .base_ld(cfg_ok && cfg_sel == SEL_RBASE),
        .stride_ld(cfg_ok && cfg_sel == SEL_RSTRIDE),
        .ld_val(cfg_data),
        .step(rd_step && !const_sel),
        .nxt(rd_nxt)
    );

    asg_lane #(.AW(AW)) u_wr_lane (
        .clk(clk), .rst_n(rst_n),
        .base_ld(cfg_ok && cfg_sel == SEL_WBASE),
        .stride_ld(cfg_ok && cfg_sel == SEL_WSTRIDE),
        .ld_val(cfg_data),
        .step(wr_step),
        .nxt(wr_addr)
    );

    asg_seq #(.CW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .stop(stop), .hold(hold),
        .rd_full(rd_full), .wr_full(wr_full), .wr_empty(wr_empty),
        .cnt_init(cnt_cfg),
        .lag(mode[MODE_LAG]), .cen(mode[MODE_CONST]), .drain(mode[MODE_DRAIN]),
        .rd_step(rd_step), .wr_step(wr_step),
        .const_sel(const_sel), .running(running)
    );

    // output strobes and read address selection
    always_comb begin
        rd_push = rd_step;
        wr_push = wr_step;
        rd_addr = const_sel ? const_addr : rd_nxt;
    end

    p_no_push_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_push |-> !rd_full) and (wr_push |-> !wr_full));
    p_no_push_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(rd_push || wr_push));
    p_one_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_push, wr_push}));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(rd_push || wr_push));
    p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && running) |=> !running);
endmodule

// File: tb/tb_strided_addr_gen.sv
module tb_strided_addr_gen;
    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int WDOG  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          start = 1'b0, stop = 1'b0, hold = 1'b0;
    logic          rd_full = 1'b0, wr_full = 1'b0, wr_empty = 1'b1;
    logic          rd_push, wr_push, running;
    logic [AW-1:0] rd_addr, wr_addr;

    strided_addr_gen #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .start(start), .stop(stop), .hold(hold),
        .rd_full(rd_full), .wr_full(wr_full), .wr_empty(wr_empty),
        .rd_push(rd_push), .rd_addr(rd_addr), .wr_push(wr_push),
        .wr_addr(wr_addr), .running(running)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0;
    logic [AW:0] exp_q[$];   // bit AW: 0 read, 1 write

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            n_fail++;
            $display("FAIL R6 watchdog: cycles=%0d expected below %0d", cycles, WDOG);
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // program registers (map per R12) and build the expected stream
    task automatic prep(input bit do_cfg, input int n,
                        input logic [AW-1:0] rb, input logic [AW-1:0] rs,
                        input logic [AW-1:0] wb, input logic [AW-1:0] ws,
                        input logic [AW-1:0] ca, input logic [2:0] md);
        logic [AW-1:0] r, w;
        if (do_cfg) begin
            cfg(3'd0, rb); cfg(3'd1, rs); cfg(3'd2, wb); cfg(3'd3, ws);
            cfg(3'd4, AW'(n - 1)); cfg(3'd5, ca); cfg(3'd6, {13'd0, md});
        end
        exp_q.delete();
        r = rb; w = wb;
        if (md[1]) exp_q.push_back({1'b0, ca});
        if (md[0]) begin
            r = r + rs; exp_q.push_back({1'b0, r});
            for (int i = 1; i < n; i++) begin
                r = r + rs; exp_q.push_back({1'b0, r});
                w = w + ws; exp_q.push_back({1'b1, w});
            end
            w = w + ws; exp_q.push_back({1'b1, w});
        end else begin
            for (int i = 0; i < n; i++) begin
                r = r + rs; exp_q.push_back({1'b0, r});
                w = w + ws; exp_q.push_back({1'b1, w});
            end
        end
    endtask

    // compare pushes against the queue head for one sampled cycle
    task automatic cmp_push(input string req);
        logic tg;
        logic er, ew;
        tg = exp_q[0][AW];
        er = !tg && !rd_full && !hold && !stop;
        ew = tg && !wr_full && !hold && !stop;
        chk(req, "rd_push", rd_push, er);
        chk(req, "wr_push", wr_push, ew);
        if (er && rd_push) begin
            chk(req, "rd_addr", rd_addr, exp_q[0][AW-1:0]);
            void'(exp_q.pop_front());
        end else if (ew && wr_push) begin
            chk(req, "wr_addr", wr_addr, exp_q[0][AW-1:0]);
            void'(exp_q.pop_front());
        end
    endtask

    // run a prepared case with random stalls; poke injects start/config mid-run
    task automatic run(input string req, input int fpct, input int hpct,
                       input bit drain, input bit poke);
        int tail = 0;
        bit done = 0;
        @(negedge clk);
        start = 1'b1; rd_full = 1'b0; wr_full = 1'b0; hold = 1'b0;
        wr_empty = !drain;
        for (int c = 0; c < 3000 && !done; c++) begin
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
            rd_full = ($urandom % 100) < fpct;
            wr_full = ($urandom % 100) < fpct;
            hold    = ($urandom % 100) < hpct;
            if (drain) wr_empty = (tail == 3);
            if (poke && c == 3) begin
                start = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd1; cfg_data = 16'h1234;
            end
            #(CLK_P/4);
            if (c == 0) chk("R6", "running after start", running, 1'b1);
            if (exp_q.size() > 0) cmp_push(req);
            else begin
                chk("R6", "no push after pattern", {rd_push, wr_push}, 2'b00);
                if (drain && tail <= 3) chk("R7", "running in drain", running, 1'b1);
                else begin
                    chk(drain ? "R7" : "R6", "running at end", running, 1'b0);
                    done = 1;
                end
                tail++;
            end
        end
        if (!done) chk(req, "run completed", 0, 1);
        rd_full = 1'b0; wr_full = 1'b0; hold = 1'b0; wr_empty = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #(CLK_P/4);
            chk("R9", "quiet after run", {running, rd_push, wr_push}, 3'b000);
        end
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        chk("R11", "running in reset", running, 1'b0);
        chk("R11", "pushes in reset", {rd_push, wr_push}, 2'b00);
        @(negedge clk); rst_n = 1'b1;
        #(CLK_P/4);
        chk("R11", "rd_addr after reset", rd_addr, 16'h0);
        chk("R11", "wr_addr after reset", wr_addr, 16'h0);
        // R11: run on reset values gives read 0 then write 0
        prep(0, 1, 0, 0, 0, 0, 0, 3'b000);
        run("R11", 0, 0, 0, 0);
        // R1, R3, R12: plain pattern, free FIFOs
        prep(1, 5, 16'h0100, 16'h0004, 16'h2000, 16'h0010, 0, 3'b000);
        run("R3", 0, 0, 0, 0);
        // R2, R9: stalls, hold, mid-run start and config write
        prep(1, 9, 16'h0040, 16'h0002, 16'h8000, 16'hFFFF, 0, 3'b000);
        run("R2", 40, 15, 0, 1);
        // R4: lagged pattern with stalls, and N = 1
        prep(1, 6, 16'h1000, 16'h0008, 16'h3000, 16'h0008, 0, 3'b001);
        run("R4", 30, 10, 0, 0);
        prep(1, 1, 16'h0010, 16'h0001, 16'h0020, 16'h0001, 0, 3'b001);
        run("R4", 0, 0, 0, 0);
        // R5: constant read before a lagged loop
        prep(1, 3, 16'h0500, 16'h0003, 16'h0600, 16'h0005, 16'hABCD, 3'b011);
        run("R5", 25, 0, 0, 0);
        // R8: wrapping bases
        prep(1, 4, 16'hFFF0, 16'h0008, 16'hFFFE, 16'h0003, 0, 3'b000);
        run("R8", 0, 0, 0, 0);
        // R7: drain wait
        prep(1, 3, 16'h0000, 16'h0010, 16'h4000, 16'h0010, 0, 3'b100);
        run("R7", 20, 0, 1, 0);
        // R10: stop mid-run
        prep(1, 8, 16'h0200, 16'h0001, 16'h0300, 16'h0001, 0, 3'b000);
        @(negedge clk); start = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); start = 1'b0; #(CLK_P/4);
            cmp_push("R10");
        end
        @(negedge clk); stop = 1'b1; #(CLK_P/4);
        chk("R10", "push in stop cycle", {rd_push, wr_push}, 2'b00);
        @(negedge clk); stop = 1'b0; #(CLK_P/4);
        chk("R10", "running after stop", running, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #(CLK_P/4);
            chk("R10", "no push after stop", {rd_push, wr_push}, 2'b00);
        end
        // random mixes
        for (int t = 0; t < 12; t++) begin
            logic [2:0] md;
            md = 3'($urandom % 8);
            prep(1, 1 + int'($urandom % 12), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), md);
            run(md[0] ? "R4" : "R3", int'($urandom % 50), int'($urandom % 20), md[2], 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule